// File: doc/BRIEF.md
# Radix-4 Butterfly

This block is the arithmetic core of one stage of a 16-point radix-4 FFT. Each cycle it can accept four complex samples, taken either from the sample memory or from the preceding stage. It returns their 4-point DFT as four complex results, which the next stage consumes. Real and imaginary parts are signed fixed-point values. Every output component is two bits wider than an input component, so no sum can overflow.

The arithmetic has two layers of complex add/subtract, eight operations in all: four additions and four subtractions. The first layer combines the even pair (x0, x2) and the odd pair (x1, x3). The second layer merges those partial results. The rotation by -j has no multiplier: it swaps the real and imaginary parts and negates the new imaginary part. The results sit in an output register whose strobe trails the input strobe by one clock. When no new set arrives, that register holds its contents.

Top module: `r4_bfly`

## Requirements
- R1: While reset is asserted (rst_n low), out_vld and all eight output components are 0.
- R2: out_vld is high in the clock cycle right after an edge where in_vld was sampled high, and low after an edge where in_vld was sampled low.
- R3: Result y0 equals x0+x1+x2+x3, computed separately on the real and the imaginary parts.
- R4: Result y2 equals x0-x1+x2-x3, computed separately on the real and the imaginary parts.
- R5: Result y1 equals (x0-x2) - j(x1-x3). Its real part is x0_re-x2_re+x1_im-x3_im. Its imaginary part is x0_im-x2_im-x1_re+x3_re.
- R6: Result y3 equals (x0-x2) + j(x1-x3). Its real part is x0_re-x2_re-x1_im+x3_im. Its imaginary part is x0_im-x2_im+x1_re-x3_re.
- R7: Inputs are W-bit two's complement and outputs are (W+2)-bit two's complement. Results are exact for any inputs, including all components at -2^(W-1) or at 2^(W-1)-1.
- R8: Outputs keep their values across any cycle in which in_vld is low, whatever the data inputs do.
- R9: With in_vld high on consecutive cycles, each input set produces its own result on the following cycle, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input sample set is valid this cycle |
| x0_re | input | W | Sample 0 real part |
| x0_im | input | W | Sample 0 imaginary part |
| x1_re | input | W | Sample 1 real part |
| x1_im | input | W | Sample 1 imaginary part |
| x2_re | input | W | Sample 2 real part |
| x2_im | input | W | Sample 2 imaginary part |
| x3_re | input | W | Sample 3 real part |
| x3_im | input | W | Sample 3 imaginary part |
| out_vld | output | 1 | Results are valid |
| y0_re | output | W+2 | Result 0 real part |
| y0_im | output | W+2 | Result 0 imaginary part |
| y1_re | output | W+2 | Result 1 real part |
| y1_im | output | W+2 | Result 1 imaginary part |
| y2_re | output | W+2 | Result 2 real part |
| y2_im | output | W+2 | Result 2 imaginary part |
| y3_re | output | W+2 | Result 3 real part |
| y3_im | output | W+2 | Result 3 imaginary part |

## Verification
The output register has two jobs that can fall in the same cycle: presenting the previous result and capturing the next set. These collide whenever in_vld stays high on consecutive cycles. The bench provokes this with back-to-back bursts of random and extreme-valued sets. A scoreboard queue holds reference results from a plain 4-point DFT that rotates by powers of -j, and each set's result must appear exactly one cycle after that set, in order. The bench also checks the opposite case. In idle gaps it changes the data inputs, and the outputs must still equal the last result.

// File: rtl/r4_bfly.sv
module r4_bfly #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic signed [W-1:0] x0_re,
  input  logic signed [W-1:0] x0_im,
  input  logic signed [W-1:0] x1_re,
  input  logic signed [W-1:0] x1_im,
  input  logic signed [W-1:0] x2_re,
  input  logic signed [W-1:0] x2_im,
  input  logic signed [W-1:0] x3_re,
  input  logic signed [W-1:0] x3_im,
  output logic                out_vld,
  output logic signed [W+1:0] y0_re,
  output logic signed [W+1:0] y0_im,
  output logic signed [W+1:0] y1_re,
  output logic signed [W+1:0] y1_im,
  output logic signed [W+1:0] y2_re,
  output logic signed [W+1:0] y2_im,
  output logic signed [W+1:0] y3_re,
  output logic signed [W+1:0] y3_im
);

  localparam int L1 = W + 1;
  localparam int L2 = W + 2;

  logic [L1-1:0] a_re, a_im, b_re, b_im, c_re, c_im, d_re, d_im;
  logic [L1-1:0] md_re, md_im;
  logic [L2-1:0] s0_re, s0_im, s1_re, s1_im, s2_re, s2_im, s3_re, s3_im;

  // layer 1: even pair and odd pair
  assign a_re = {x0_re[W-1], x0_re} + {x2_re[W-1], x2_re};
  assign a_im = {x0_im[W-1], x0_im} + {x2_im[W-1], x2_im};
  assign b_re = {x0_re[W-1], x0_re} - {x2_re[W-1], x2_re};
  assign b_im = {x0_im[W-1], x0_im} - {x2_im[W-1], x2_im};
  assign c_re = {x1_re[W-1], x1_re} + {x3_re[W-1], x3_re};
  assign c_im = {x1_im[W-1], x1_im} + {x3_im[W-1], x3_im};
  assign d_re = {x1_re[W-1], x1_re} - {x3_re[W-1], x3_re};
  assign d_im = {x1_im[W-1], x1_im} - {x3_im[W-1], x3_im};

  // -j * d : swap parts, negate the new imaginary part
  assign md_re = d_im;
  assign md_im = -d_re;

  // layer 2
  assign s0_re = {a_re[L1-1], a_re} + {c_re[L1-1], c_re};
  assign s0_im = {a_im[L1-1], a_im} + {c_im[L1-1], c_im};
  assign s2_re = {a_re[L1-1], a_re} - {c_re[L1-1], c_re};
  assign s2_im = {a_im[L1-1], a_im} - {c_im[L1-1], c_im};
  assign s1_re = {b_re[L1-1], b_re} + {md_re[L1-1], md_re};
  assign s1_im = {b_im[L1-1], b_im} + {md_im[L1-1], md_im};
  assign s3_re = {b_re[L1-1], b_re} - {md_re[L1-1], md_re};
  assign s3_im = {b_im[L1-1], b_im} - {md_im[L1-1], md_im};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      y0_re <= '0; y0_im <= '0;
      y1_re <= '0; y1_im <= '0;
      y2_re <= '0; y2_im <= '0;
      y3_re <= '0; y3_im <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        y0_re <= s0_re; y0_im <= s0_im;
        y1_re <= s1_re; y1_im <= s1_im;
        y2_re <= s2_re; y2_im <= s2_im;
        y3_re <= s3_re; y3_im <= s3_im;
      end
    end
  end

  // checking nets: output pair sums against doubled input pair sums
  logic [W+2:0] o02_re, o13_re, i02_re, i02d_re;
  assign o02_re  = {y0_re[W+1], y0_re} + {y2_re[W+1], y2_re};
  assign o13_re  = {y1_re[W+1], y1_re} + {y3_re[W+1], y3_re};
  assign i02_re  = {x0_re[W-1], x0_re[W-1], x0_re, 1'b0} + {x2_re[W-1], x2_re[W-1], x2_re, 1'b0};
  assign i02d_re = {x0_re[W-1], x0_re[W-1], x0_re, 1'b0} - {x2_re[W-1], x2_re[W-1], x2_re, 1'b0};

  // R2
  vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) in_vld |=> out_vld);
  // R2
  vld_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_vld |=> !out_vld);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(y0_re) && $stable(y0_im) && $stable(y1_re) && $stable(y1_im) &&
                 $stable(y2_re) && $stable(y2_im) && $stable(y3_re) && $stable(y3_im)));
  // R3 R4 R7
  even_sum_chk: assert property (@(posedge clk) disable iff (!rst_n) in_vld |=> o02_re == $past(i02_re));
  // R5 R6 R7
  odd_sum_chk: assert property (@(posedge clk) disable iff (!rst_n) in_vld |=> o13_re == $past(i02d_re));

endmodule

// File: tb/sim_r4_bfly.sv
`timescale 1ns/1ps
module sim_r4_bfly;
  localparam int W = 16;
  localparam int MAXV = (1 << (W-1)) - 1;
  localparam int MINV = -(1 << (W-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic signed [W-1:0] x0_re = '0, x0_im = '0, x1_re = '0, x1_im = '0;
  logic signed [W-1:0] x2_re = '0, x2_im = '0, x3_re = '0, x3_im = '0;
  logic out_vld;
  logic signed [W+1:0] y0_re, y0_im, y1_re, y1_im, y2_re, y2_im, y3_re, y3_im;

  always #2 clk = ~clk;

  r4_bfly #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .x0_re(x0_re), .x0_im(x0_im), .x1_re(x1_re), .x1_im(x1_im),
    .x2_re(x2_re), .x2_im(x2_im), .x3_re(x3_re), .x3_im(x3_im),
    .out_vld(out_vld),
    .y0_re(y0_re), .y0_im(y0_im), .y1_re(y1_re), .y1_im(y1_im),
    .y2_re(y2_re), .y2_im(y2_im), .y3_re(y3_re), .y3_im(y3_im)
  );

  int checks = 0;
  int failures = 0;
  int q[$];
  int last[8];
  bit have_last = 0;
  bit done = 0;
  int dr[4], di[4];

  task automatic chk(string req, int got_r, int got_i, int exp_r, int exp_i);
    checks++;
    if (got_r !== exp_r || got_i !== exp_i) begin
      failures++;
      $display("FAIL %s actual=(%0d,%0d) expected=(%0d,%0d)", req, got_r, got_i, exp_r, exp_i);
    end
  endtask

  // reference 4-point DFT: X[k] = sum x[n] * (-j)^(n*k)
  task automatic push_ref();
    for (int k = 0; k < 4; k++) begin
      int sr = 0, si = 0;
      for (int n = 0; n < 4; n++) begin
        case ((n * k) % 4)
          0: begin sr += dr[n];  si += di[n];  end
          1: begin sr += di[n];  si -= dr[n];  end
          2: begin sr -= dr[n];  si -= di[n];  end
          default: begin sr -= di[n]; si += dr[n]; end
        endcase
      end
      q.push_back(sr);
      q.push_back(si);
    end
  endtask

  task automatic apply();
    x0_re = W'(dr[0]); x0_im = W'(di[0]);
    x1_re = W'(dr[1]); x1_im = W'(di[1]);
    x2_re = W'(dr[2]); x2_im = W'(di[2]);
    x3_re = W'(dr[3]); x3_im = W'(di[3]);
  endtask

  task automatic send();
    @(negedge clk);
    apply();
    in_vld = 1'b1;
    push_ref();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
      for (int j = 0; j < 4; j++) begin
        dr[j] = $urandom_range(65535) - 32768;
        di[j] = $urandom_range(65535) - 32768;
      end
      apply();
    end
  endtask

  task automatic rnd();
    for (int j = 0; j < 4; j++) begin
      dr[j] = $urandom_range(65535) - 32768;
      di[j] = $urandom_range(65535) - 32768;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_vld) begin
        if (q.size() < 8) begin
          checks++; failures++;
          $display("FAIL R9 actual=unexpected result expected=no result");
        end else begin
          for (int i = 0; i < 8; i++) last[i] = q.pop_front();
          have_last = 1;
          chk("R3", int'(y0_re), int'(y0_im), last[0], last[1]);
          chk("R5", int'(y1_re), int'(y1_im), last[2], last[3]);
          chk("R4", int'(y2_re), int'(y2_im), last[4], last[5]);
          chk("R6", int'(y3_re), int'(y3_im), last[6], last[7]);
        end
      end else if (rst_n && have_last) begin
        // R8: idle cycle, inputs are being changed
        chk("R8 y0", int'(y0_re), int'(y0_im), last[0], last[1]);
        chk("R8 y3", int'(y3_re), int'(y3_im), last[6], last[7]);
      end
    end
  end

  // watchdog
  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state, inputs active during reset
    in_vld = 1'b1;
    rnd(); apply();
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_vld !== 1'b0) begin
      failures++;
      $display("FAIL R1 actual=%0b expected=0", out_vld);
    end
    chk("R1 y0", int'(y0_re), int'(y0_im), 0, 0);
    chk("R1 y1", int'(y1_re), int'(y1_im), 0, 0);
    chk("R1 y2", int'(y2_re), int'(y2_im), 0, 0);
    chk("R1 y3", int'(y3_re), int'(y3_im), 0, 0);
    in_vld = 1'b0;
    rst_n = 1'b1;
    idle(2);

    // R2: single set, strobe timing
    dr = '{1, 2, 3, 4}; di = '{0, -1, 5, 7};
    send();
    @(negedge clk);
    in_vld = 1'b0;
    checks++;
    if (out_vld !== 1'b1) begin
      failures++;
      $display("FAIL R2 actual=%0b expected=1", out_vld);
    end
    @(negedge clk);
    checks++;
    if (out_vld !== 1'b0) begin
      failures++;
      $display("FAIL R2 actual=%0b expected=0", out_vld);
    end
    idle(3);

    // R7: extreme values
    dr = '{MINV, MINV, MINV, MINV}; di = '{MINV, MINV, MINV, MINV};
    send();
    dr = '{MAXV, MAXV, MAXV, MAXV}; di = '{MAXV, MAXV, MAXV, MAXV};
    send();
    dr = '{MAXV, MINV, MINV, MAXV}; di = '{MINV, MAXV, MAXV, MINV};
    send();
    dr = '{MAXV, MAXV, MINV, MINV}; di = '{MAXV, MAXV, MINV, MINV};
    send();
    dr = '{MINV, MINV, MAXV, MAXV}; di = '{MINV, MAXV, MAXV, MINV};
    send();
    idle(3);

    // R3 R4 R5 R6 with random sets and gaps (R8 checked in gaps)
    for (int t = 0; t < 40; t++) begin
      rnd();
      send();
      idle(1 + (t % 3));
    end

    // R9: back-to-back bursts
    for (int b = 0; b < 10; b++) begin
      for (int t = 0; t < 20; t++) begin
        rnd();
        send();
      end
      idle(2);
    end

    idle(4);
    if (q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R9 actual=%0d pending expected=0", q.size() / 8);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule